// File: doc/BRIEF.md
# Cartridge Memory Bank Controller

This block sits between an 8-bit CPU's 16-bit address bus and a cartridge's external memories. It turns CPU reads into physical addresses on a large external ROM and a banked external RAM. CPU writes into ROM address space do not reach the ROM. They load the controller's registers instead: the external-RAM window enable, the switchable ROM bank, a shared selector for RAM banks and clock registers, and the clock-latch command.

The lower 16 KiB of CPU space is always the first ROM page. The upper 16 KiB of ROM space shows whichever bank the ROM bank register names. The 8 KiB window at 0xA000 reaches either one of the external RAM banks or, when the shared selector holds a clock code, a clock register. In the clock case the block raises a clock-register select with an index and reads back 0x00. The block does not contain a counting clock; it only decodes the select and produces a one-cycle latch pulse. The CPU read data is muxed inside the block from the ROM and RAM data inputs. An invalid-access flag marks unsupported addresses and rejected register values.

Top module: `cart_bank_ctrl`

## Requirements
- R1: A read of 0x0000–0x3FFF asserts rom_cs_o with rom_addr_o equal to the CPU address, whatever the ROM bank register holds, and returns rom_data_i on cpu_rdata_o.
- R2: A read of 0x4000–0x7FFF asserts rom_cs_o with rom_addr_o = bank × 0x4000 + (address − 0x4000). Bank 0 is used as given, not remapped.
- R3: A write to 0x2000–0x3FFF loads the ROM bank register with data bits [6:0] from the next clock edge on. Bit 7 is dropped, and rom_cs_o stays low on any write.
- R4: A write to 0x0000–0x1FFF of 0x0A enables the 0xA000 window and a write of 0x00 disables it. Any other value leaves the enable unchanged.
- R5: A write to 0x4000–0x5FFF of 0x00–0x03 or 0x08–0x0C loads the shared selector. Any other value raises invalid_o in the write cycle and leaves the selector unchanged.
- R6: With the window enabled and selector 0–3, an access to 0xA000–0xBFFF asserts ram_cs_o with ram_addr_o = selector × 0x2000 + (address − 0xA000). A write also asserts ram_we_o, and a read returns ram_data_i.
- R7: With the window enabled and selector 0x08–0x0C, an access to 0xA000–0xBFFF asserts clk_sel_o with clk_idx_o = selector − 8. It asserts neither ram_cs_o nor ram_we_o, and a read returns 0x00.
- R8: With the window disabled, reads of 0xA000–0xBFFF return 0xFF, and ram_cs_o, ram_we_o and clk_sel_o stay low.
- R9: A write to 0x6000–0x7FFF accepts only 0x00 and 0x01; other values raise invalid_o and change nothing. latch_pulse_o is high for exactly the one cycle after a 0x01 write whose most recent accepted latch write was 0x00.
- R10: A read or write of 0x8000–0x9FFF or 0xC000–0xFFFF asserts no chip select, raises invalid_o in that cycle and reads 0xFF. With no strobe, invalid_o is low.
- R11: After reset the ROM bank register is 1, the selector is 0, the window is disabled and latch_pulse_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | CPU address |
| wdata_i | input | 8 | CPU write data |
| rd_i | input | 1 | CPU read strobe |
| wr_i | input | 1 | CPU write strobe |
| rom_data_i | input | 8 | Data from external ROM |
| ram_data_i | input | 8 | Data from external RAM |
| cpu_rdata_o | output | 8 | Read data to CPU |
| rom_addr_o | output | 21 | Physical ROM address |
| rom_cs_o | output | 1 | ROM chip select (reads) |
| ram_addr_o | output | 15 | Physical RAM address |
| ram_cs_o | output | 1 | RAM chip select |
| ram_we_o | output | 1 | RAM write enable |
| clk_sel_o | output | 1 | Clock-register select |
| clk_idx_o | output | 3 | Clock-register index (selector − 8) |
| latch_pulse_o | output | 1 | One-cycle clock latch pulse |
| invalid_o | output | 1 | Unsupported access or rejected register value |

## Verification
The hardest state to reach from the ports is the latch arming. A pulse depends on the last accepted latch value, so the bench plays ordered sequences: 0x01 straight after reset, 0x00 then 0x01, a repeated 0x01, and a rejected 0x02 between 0x00 and 0x01. It checks the pulse in the one cycle where it should appear and in the cycle after. The shared selector is not visible directly. The bench therefore reads it back through ram_addr_o and clk_idx_o after each rejected write, with the window enabled. It then disables the window to show that the clock select is gated too.

// File: rtl/cart_bank_pkg.sv
`timescale 1ns/1ps
package cart_bank_pkg;
  localparam int ROM_PAGE_W = 14;
  localparam int RAM_PAGE_W = 13;
  localparam int SEL_W      = 4;

  localparam logic [7:0] EN_ON_VAL   = 8'h0A;
  localparam logic [7:0] EN_OFF_VAL  = 8'h00;
  localparam logic [7:0] CLK_SEL_MIN = 8'h08;
  localparam logic [7:0] CLK_SEL_MAX = 8'h0C;
  localparam logic [7:0] OPEN_BUS    = 8'hFF;
  localparam logic [7:0] CLK_RDATA   = 8'h00;

  typedef enum logic [1:0] {
    RG_ROM0 = 2'd0,
    RG_ROMX = 2'd1,
    RG_WIN  = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    CT_ENABLE  = 2'd0,
    CT_ROMBANK = 2'd1,
    CT_SEL     = 2'd2,
    CT_LATCH   = 2'd3
  } ctl_e;

  function automatic region_e region_of(input logic [2:0] top3);
    case (top3)
      3'b000, 3'b001: region_of = RG_ROM0;
      3'b010, 3'b011: region_of = RG_ROMX;
      3'b101:         region_of = RG_WIN;
      default:        region_of = RG_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cart_bank_regs.sv
`timescale 1ns/1ps
module cart_bank_regs
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [2:0]            addr_top_i,
  input  logic [7:0]            wdata_i,
  output logic [ROM_BANK_W-1:0] rom_bank_o,
  output logic [SEL_W-1:0]      sel_o,
  output logic                  win_en_o,
  output logic                  latch_pulse_o,
  output logic                  reg_inval_o
);
  localparam logic [7:0] RAM_SEL_LIM = 8'(1 << RAM_BANK_W);

  logic                  ctl_hit;
  ctl_e                  ctl;
  logic                  sel_ok;
  logic                  latch_ok;
  logic                  en_known;
  logic [ROM_BANK_W-1:0] rom_bank_q;
  logic [SEL_W-1:0]      sel_q;
  logic                  win_en_q;
  logic                  armed_q;
  logic                  pulse_q;

  assign ctl_hit  = wr_i && !addr_top_i[2];
  assign ctl      = ctl_e'(addr_top_i[1:0]);
  assign sel_ok   = (wdata_i < RAM_SEL_LIM) ||
                    (wdata_i >= CLK_SEL_MIN && wdata_i <= CLK_SEL_MAX);
  assign latch_ok = (wdata_i[7:1] == 7'd0);
  assign en_known = (wdata_i == EN_ON_VAL) || (wdata_i == EN_OFF_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rom_bank_q <= ROM_BANK_W'(1);
      sel_q      <= '0;
      win_en_q   <= 1'b0;
      armed_q    <= 1'b0;
      pulse_q    <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (ctl_hit) begin
        case (ctl)
          CT_ENABLE: begin
            if (wdata_i == EN_ON_VAL)       win_en_q <= 1'b1;
            else if (wdata_i == EN_OFF_VAL) win_en_q <= 1'b0;
          end
          CT_ROMBANK: rom_bank_q <= wdata_i[ROM_BANK_W-1:0];
          CT_SEL: if (sel_ok) sel_q <= wdata_i[SEL_W-1:0];
          CT_LATCH: if (latch_ok) begin
            armed_q <= !wdata_i[0];
            pulse_q <= wdata_i[0] && armed_q;
          end
          default: ;
        endcase
      end
    end
  end

  assign reg_inval_o   = ctl_hit && (((ctl == CT_SEL) && !sel_ok) ||
                                     ((ctl == CT_LATCH) && !latch_ok));
  assign rom_bank_o    = rom_bank_q;
  assign sel_o         = sel_q;
  assign win_en_o      = win_en_q;
  assign latch_pulse_o = pulse_q;

  AST_ROM_BANK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_top_i == 3'b001) |=> rom_bank_q == $past(wdata_i[ROM_BANK_W-1:0])); // R3
  AST_EN_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_top_i == 3'b000 && !en_known) |=> win_en_q == $past(win_en_q)); // R4
  AST_SEL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_top_i == 3'b010 && !sel_ok) |=> sel_q == $past(sel_q)); // R5
  AST_SEL_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_q < SEL_W'(RAM_SEL_LIM)) || (sel_q >= 4'h8 && sel_q <= 4'hC)); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q); // R9
  AST_PULSE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_q) |-> $past(wr_i && addr_top_i == 3'b011 && wdata_i == 8'h01)); // R9
endmodule

// File: rtl/cart_bank_map.sv
`timescale 1ns/1ps
module cart_bank_map
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_ADDR_W = ROM_PAGE_W + ROM_BANK_W,
  localparam int RAM_ADDR_W = RAM_PAGE_W + RAM_BANK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [15:0]           addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [ROM_BANK_W-1:0] rom_bank_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  win_en_i,
  input  logic [7:0]            rom_data_i,
  input  logic [7:0]            ram_data_i,
  output logic [7:0]            rdata_o,
  output logic [ROM_ADDR_W-1:0] rom_addr_o,
  output logic                  rom_cs_o,
  output logic [RAM_ADDR_W-1:0] ram_addr_o,
  output logic                  ram_cs_o,
  output logic                  ram_we_o,
  output logic                  clk_sel_o,
  output logic [2:0]            clk_idx_o,
  output logic                  map_inval_o
);
  region_e region;
  logic    strobe;
  logic    win_hit;
  logic    sel_is_clk;

  assign region     = region_of(addr_i[15:13]);
  assign strobe     = rd_i || wr_i;
  assign win_hit    = strobe && (region == RG_WIN) && win_en_i;
  assign sel_is_clk = sel_i[SEL_W-1];

  always_comb begin
    rom_addr_o = '0;
    rom_addr_o[ROM_PAGE_W-1:0] = addr_i[ROM_PAGE_W-1:0];
    if (region == RG_ROMX) rom_addr_o[ROM_ADDR_W-1:ROM_PAGE_W] = rom_bank_i;
  end

  assign ram_addr_o  = {sel_i[RAM_BANK_W-1:0], addr_i[RAM_PAGE_W-1:0]};
  assign clk_idx_o   = sel_i[2:0];
  assign rom_cs_o    = rd_i && ((region == RG_ROM0) || (region == RG_ROMX));
  assign ram_cs_o    = win_hit && !sel_is_clk;
  assign ram_we_o    = ram_cs_o && wr_i;
  assign clk_sel_o   = win_hit && sel_is_clk;
  assign map_inval_o = strobe && (region == RG_NONE);

  always_comb begin
    unique case (region)
      RG_ROM0, RG_ROMX: rdata_o = rom_data_i;
      RG_WIN: begin
        if (!win_en_i)       rdata_o = OPEN_BUS;
        else if (sel_is_clk) rdata_o = CLK_RDATA;
        else                 rdata_o = ram_data_i;
      end
      default: rdata_o = OPEN_BUS;
    endcase
  end

  AST_CS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rom_cs_o, ram_cs_o, clk_sel_o})); // R7
  AST_WIN_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_en_i |-> !ram_cs_o && !ram_we_o && !clk_sel_o); // R8
  AST_ROM_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i) |-> !rom_cs_o); // R3
  AST_HOLE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_inval_o |-> !rom_cs_o && !ram_cs_o && !clk_sel_o && rdata_o == 8'hFF); // R10
endmodule

// File: rtl/cart_bank_ctrl.sv
`timescale 1ns/1ps
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int ROM_BANK_W = 7,
  parameter int RAM_BANK_W = 2,
  localparam int ROM_ADDR_W = ROM_PAGE_W + ROM_BANK_W,
  localparam int RAM_ADDR_W = RAM_PAGE_W + RAM_BANK_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [15:0]           addr_i,
  input  logic [7:0]            wdata_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [7:0]            rom_data_i,
  input  logic [7:0]            ram_data_i,
  output logic [7:0]            cpu_rdata_o,
  output logic [ROM_ADDR_W-1:0] rom_addr_o,
  output logic                  rom_cs_o,
  output logic [RAM_ADDR_W-1:0] ram_addr_o,
  output logic                  ram_cs_o,
  output logic                  ram_we_o,
  output logic                  clk_sel_o,
  output logic [2:0]            clk_idx_o,
  output logic                  latch_pulse_o,
  output logic                  invalid_o
);
  logic [ROM_BANK_W-1:0] rom_bank;
  logic [SEL_W-1:0]      sel;
  logic                  win_en;
  logic                  reg_inval;
  logic                  map_inval;

  cart_bank_regs #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_i          (wr_i),
    .addr_top_i    (addr_i[15:13]),
    .wdata_i       (wdata_i),
    .rom_bank_o    (rom_bank),
    .sel_o         (sel),
    .win_en_o      (win_en),
    .latch_pulse_o (latch_pulse_o),
    .reg_inval_o   (reg_inval)
  );

  cart_bank_map #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .addr_i      (addr_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .rom_bank_i  (rom_bank),
    .sel_i       (sel),
    .win_en_i    (win_en),
    .rom_data_i  (rom_data_i),
    .ram_data_i  (ram_data_i),
    .rdata_o     (cpu_rdata_o),
    .rom_addr_o  (rom_addr_o),
    .rom_cs_o    (rom_cs_o),
    .ram_addr_o  (ram_addr_o),
    .ram_cs_o    (ram_cs_o),
    .ram_we_o    (ram_we_o),
    .clk_sel_o   (clk_sel_o),
    .clk_idx_o   (clk_idx_o),
    .map_inval_o (map_inval)
  );

  assign invalid_o = reg_inval || map_inval;

  AST_ROM0_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[15:14] == 2'b00) |-> rom_addr_o == ROM_ADDR_W'(addr_i)); // R1
  AST_ROMX_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i[15:14] == 2'b01) |-> rom_addr_o[ROM_ADDR_W-1:ROM_PAGE_W] == rom_bank); // R2
  AST_IDLE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !wr_i) |-> !invalid_o); // R10
endmodule

// File: tb/cart_bank_ctrl_test.sv
`timescale 1ns/1ps
module cart_bank_ctrl_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  rom_data;
  logic [7:0]  ram_data;
  logic [7:0]  rdata;
  logic [20:0] rom_addr;
  logic        rom_cs;
  logic [14:0] ram_addr;
  logic        ram_cs;
  logic        ram_we;
  logic        clk_sel;
  logic [2:0]  clk_idx;
  logic        latch_pulse;
  logic        invalid;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  function automatic logic [7:0] rom_f(input logic [20:0] a);
    return a[7:0] ^ {1'b0, a[20:14]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] ram_f(input logic [14:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'hA5;
  endfunction

  assign rom_data = rom_f(rom_addr);
  assign ram_data = ram_f(ram_addr);

  cart_bank_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rom_data_i(rom_data), .ram_data_i(ram_data),
    .cpu_rdata_o(rdata), .rom_addr_o(rom_addr), .rom_cs_o(rom_cs),
    .ram_addr_o(ram_addr), .ram_cs_o(ram_cs), .ram_we_o(ram_we),
    .clk_sel_o(clk_sel), .clk_idx_o(clk_idx), .latch_pulse_o(latch_pulse),
    .invalid_o(invalid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // inputs change at negedge; combinational outputs sampled 1 ns later
  task automatic rd_at(input logic [15:0] a);
    @(negedge clk_i); rd = 1'b1; wr = 1'b0; addr = a; wdata = 8'h00; #1;
  endtask
  task automatic wr_at(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i); rd = 1'b0; wr = 1'b1; addr = a; wdata = d; #1;
  endtask
  task automatic idle();
    @(negedge clk_i); rd = 1'b0; wr = 1'b0; addr = 16'h0000; #1;
  endtask
  task automatic put(input logic [15:0] a, input logic [7:0] d);
    wr_at(a, d); idle();
  endtask

  task automatic t_reset();
    idle();
    chk("R11 pulse low", latch_pulse, 0);
    chk("R10 idle no invalid", invalid, 0);
    rd_at(16'h4000);
    chk("R11 rom bank 1", rom_addr, 21'h04000);
    rd_at(16'hA000);
    chk("R11 window off rdata", rdata, 8'hFF);
    chk("R11 window off ram_cs", ram_cs, 0);
    idle();
    put(16'h0000, 8'h0A);
    rd_at(16'hA123);
    chk("R11 sel 0 ram_addr", ram_addr, 15'h0123);
    chk("R11 sel 0 ram_cs", ram_cs, 1);
    idle();
    put(16'h0000, 8'h00);
  endtask

  task automatic t_rom();
    wr_at(16'h2000, 8'h85);
    chk("R3 no rom_cs on write", rom_cs, 0);
    idle();
    rd_at(16'h1234);
    chk("R1 fixed page addr", rom_addr, 21'h01234);
    chk("R1 rom_cs", rom_cs, 1);
    chk("R1 rdata", rdata, rom_f(21'h01234));
    rd_at(16'h7FFF);
    chk("R3 bit7 dropped, bank 5", rom_addr, 21'h17FFF);
    chk("R2 rdata", rdata, rom_f(21'h17FFF));
    idle();
    put(16'h3FFF, 8'hFF);
    rd_at(16'h4000);
    chk("R2 bank 0x7F", rom_addr, 21'h1FC000);
    rd_at(16'h3FFF);
    chk("R1 bank ignored", rom_addr, 21'h03FFF);
    idle();
    put(16'h2ABC, 8'h00);
    rd_at(16'h4001);
    chk("R2 bank 0 not remapped", rom_addr, 21'h00001);
    chk("R2 rom_cs", rom_cs, 1);
    idle();
  endtask

  task automatic t_enable();
    put(16'h1FFF, 8'h0A);
    rd_at(16'hA000);
    chk("R4 enabled ram_cs", ram_cs, 1);
    idle();
    put(16'h0123, 8'h55);
    rd_at(16'hA000);
    chk("R4 other value keeps enable", ram_cs, 1);
    idle();
    put(16'h0000, 8'h00);
    rd_at(16'hA000);
    chk("R8 disabled ram_cs", ram_cs, 0);
    chk("R8 disabled rdata", rdata, 8'hFF);
    wr_at(16'hA001, 8'h77);
    chk("R8 disabled no we", ram_we, 0);
    idle();
    put(16'h0000, 8'h33);
    rd_at(16'hA000);
    chk("R4 other value keeps disable", ram_cs, 0);
    idle();
    put(16'h0000, 8'h0A);
  endtask

  task automatic t_ram();
    put(16'h4000, 8'h02);
    rd_at(16'hBFFF);
    chk("R6 ram_addr bank 2", ram_addr, 15'h5FFF);
    chk("R6 ram_cs", ram_cs, 1);
    chk("R6 ram_we low on read", ram_we, 0);
    chk("R6 rdata", rdata, ram_f(15'h5FFF));
    wr_at(16'hA010, 8'h99);
    chk("R6 write addr", ram_addr, 15'h4010);
    chk("R6 ram_we", ram_we, 1);
    idle();
    put(16'h5000, 8'h03);
    rd_at(16'hA000);
    chk("R6 bank 3", ram_addr, 15'h6000);
    idle();
    put(16'h4000, 8'h02);
  endtask

  task automatic t_sel_clk();
    wr_at(16'h5FFF, 8'h05);
    chk("R5 0x05 invalid", invalid, 1);
    idle();
    rd_at(16'hA000);
    chk("R5 sel kept after 0x05", ram_addr, 15'h4000);
    idle();
    wr_at(16'h4000, 8'h0D);
    chk("R5 0x0D invalid", invalid, 1);
    idle();
    rd_at(16'hA000);
    chk("R5 sel kept after 0x0D", ram_addr, 15'h4000);
    idle();
    wr_at(16'h4000, 8'h0C);
    chk("R5 0x0C accepted", invalid, 0);
    idle();
    rd_at(16'hA456);
    chk("R7 clk_sel", clk_sel, 1);
    chk("R7 idx 4", clk_idx, 3'd4);
    chk("R7 no ram_cs", ram_cs, 0);
    chk("R7 rdata 00", rdata, 8'h00);
    wr_at(16'hB000, 8'h12);
    chk("R7 write no we", ram_we, 0);
    chk("R7 write clk_sel", clk_sel, 1);
    idle();
    put(16'h4000, 8'h08);
    rd_at(16'hA000);
    chk("R7 idx 0", clk_idx, 3'd0);
    chk("R7 clk_sel at 08", clk_sel, 1);
    idle();
    put(16'h0000, 8'h00);
    rd_at(16'hA000);
    chk("R8 disabled clk_sel", clk_sel, 0);
    chk("R8 disabled clk rdata", rdata, 8'hFF);
    idle();
    put(16'h0000, 8'h0A);
  endtask

  task automatic t_latch();
    wr_at(16'h6000, 8'h01);
    chk("R9 valid 01", invalid, 0);
    idle();
    chk("R9 01 unarmed no pulse", latch_pulse, 0);
    put(16'h6000, 8'h00);
    chk("R9 00 no pulse", latch_pulse, 0);
    wr_at(16'h7FFF, 8'h01);
    idle();
    chk("R9 pulse after 00,01", latch_pulse, 1);
    idle();
    chk("R9 pulse one cycle", latch_pulse, 0);
    put(16'h6000, 8'h01);
    chk("R9 repeat 01 no pulse", latch_pulse, 0);
    put(16'h6000, 8'h00);
    wr_at(16'h6000, 8'h02);
    chk("R9 0x02 invalid", invalid, 1);
    idle();
    chk("R9 no pulse on 02", latch_pulse, 0);
    put(16'h6000, 8'h01);
    chk("R9 02 ignored, pulse", latch_pulse, 1);
    idle();
    chk("R9 pulse dropped", latch_pulse, 0);
  endtask

  task automatic t_holes();
    rd_at(16'h8000);
    chk("R10 8000 invalid", invalid, 1);
    chk("R10 8000 cs", {rom_cs, ram_cs, clk_sel}, 0);
    chk("R10 8000 rdata", rdata, 8'hFF);
    rd_at(16'hC000);
    chk("R10 C000 invalid", invalid, 1);
    chk("R10 C000 cs", {rom_cs, ram_cs, clk_sel}, 0);
    rd_at(16'hFFFF);
    chk("R10 FFFF invalid", invalid, 1);
    chk("R10 FFFF rdata", rdata, 8'hFF);
    wr_at(16'h9000, 8'h44);
    chk("R10 write hole invalid", invalid, 1);
    chk("R10 write hole no we", ram_we, 0);
    idle();
    chk("R10 idle clears invalid", invalid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    t_reset();
    t_rom();
    t_enable();
    t_ram();
    t_sel_clk();
    t_latch();
    t_holes();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule